// File: doc/BRIEF.md
# Windowed Serial Signature Analyzer

This block compacts the bit stream seen on one monitored node into a 16-bit signature. Three control lines from the logic under observation set when that happens: a start event opens a capture window, a stop event closes it, and each qualifying edge on a sample-clock line inside the window feeds the current level of the data line into a linear feedback shift register. The line sampled is the data line; the other three lines only set the timing. Each of the three control lines has its own select that picks whether its rising or its falling edge is the active one.

All four probe lines may be asynchronous to the system clock. They pass through two-flop synchronisers, and edge detection happens in the system clock domain. When the window closes, a done flag rises and stays up until the next start. The signature is available as a binary word and also as four display characters, one per nibble. The character set uses the numerals for 0 to 9 and the letters A, C, F, H, P, U for 10 to 15. A compare output reports whether the finished signature equals a supplied expected word. A window run again over a repeatable stream yields the same signature, so a mismatch points at a faulty node.

Top module: `sigan_top`

## Requirements
- R1: After reset the signature is 0x0000, done and match are 0, and the characters read "0000" (ASCII 0x30 in every byte).
- R2: Each probe line passes through two synchroniser flops. A level change applied between system clock edges takes effect on the outputs at the third rising system clock edge after it, and not earlier.
- R3: A start event clears the signature to zero, clears done and opens the window, whatever state the block was in before.
- R4: A sample-clock event while the window is open advances the register by one step. With feedback f = sig[15] XOR data, the next value is {sig[14:0],0} XOR (f ? 0x1281 : 0), which implements x^16+x^12+x^9+x^7+1.
- R5: Sample-clock events while the window is closed, both before the first start and after a stop, leave the signature unchanged.
- R6: A stop event while the window is open closes it and sets done. Done stays at 1 until the next start event. A stop event while the window is closed changes nothing.
- R7: Each of the start, stop and sample-clock lines has its own polarity select: 0 makes the rising edge active, and 1 makes the falling edge active. An edge of the inactive direction causes no event.
- R8: When a stop event and a sample-clock event are detected in the same system cycle, the stop wins and that data bit is not compacted.
- R9: glyph_o holds one ASCII character per nibble, with the most significant nibble in bits 31:24. Nibble values 0 to 9 map to '0' to '9', and values 10 to 15 map to 'A','C','F','H','P','U' in that order.
- R10: match_o is 1 only while done is 1 and the signature equals expect_i.
- R11: Running the same window twice over the same stream gives identical signatures.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Asynchronous start probe line |
| stop_i | input | 1 | Asynchronous stop probe line |
| sclk_i | input | 1 | Asynchronous sample-clock probe line |
| data_i | input | 1 | Asynchronous monitored data line |
| start_fall_i | input | 1 | 1: start acts on the falling edge, 0: on the rising edge |
| stop_fall_i | input | 1 | 1: stop acts on the falling edge, 0: on the rising edge |
| sclk_fall_i | input | 1 | 1: sample clock acts on the falling edge, 0: on the rising edge |
| expect_i | input | 16 | Expected signature for the compare |
| done_o | output | 1 | Window has closed; held until the next start |
| sig_o | output | 16 | Signature register contents |
| glyph_o | output | 32 | Signature as four ASCII display characters |
| match_o | output | 1 | Done and signature equals expect_i |

## Verification
Any wrong bit in the shift register carries forward through every later step. One bad feedback tap or one dropped or extra sample therefore shows as a wrong sig_o and wrong characters when the window closes, a few system cycles after the stop edge. A window-state error, such as a window left open or done released early, shows as a signature that moves under sample-clock edges outside the window, or as done falling without a start. Three-cycle latency checks around a start edge expose a missing or an extra synchroniser stage straight away.

// File: rtl/sigan_pkg.sv
// Shared definitions for the windowed signature analyzer.
// Assumes signatures are a whole number of 4-bit digits.
package sigan_pkg;

    // Index of each probe control line inside the event vector
    localparam int unsigned EV_START = 0;
    localparam int unsigned EV_STOP  = 1;
    localparam int unsigned EV_SCLK  = 2;
    localparam int unsigned EV_N     = 3;

    // Map one nibble to its ASCII display character
    function automatic logic [7:0] nib_to_char(input logic [3:0] v);
        logic [7:0] c;
        if (v < 4'd10) begin
            c = 8'h30 + {4'd0, v};
        end else begin
            case (v)
                4'd10:   c = 8'h41; // A
                4'd11:   c = 8'h43; // C
                4'd12:   c = 8'h46; // F
                4'd13:   c = 8'h48; // H
                4'd14:   c = 8'h50; // P
                default: c = 8'h55; // U
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/sigan_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous single-bit lines.
// Assumes each line is independent; no bus coherence is implied.
module sigan_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift every line through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sigan_edge.sv
// Edge detector with per-line polarity select.
// Assumes the inputs are already synchronous to clk.
module sigan_edge #(
    parameter int unsigned WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    input  logic [WIDTH-1:0] fall_sel,
    output logic [WIDTH-1:0] ev
);
    logic [WIDTH-1:0] prev;

    // Remember the previous synchronised level
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    // Pick the active edge for each line
    for (genvar g = 0; g < WIDTH; g++) begin : g_edge
        assign ev[g] = fall_sel[g] ? (prev[g] & ~lvl[g]) : (~prev[g] & lvl[g]);
    end
endmodule

// File: rtl/sigan_window.sv
// Capture-window control: start opens and clears, stop closes and flags done.
// Assumes event pulses last one cycle; start has priority over stop.
module sigan_window (
    input  logic clk,
    input  logic rst_n,
    input  logic start_ev,
    input  logic stop_ev,
    input  logic sclk_ev,
    output logic clear,
    output logic step,
    output logic win_open,
    output logic done
);
    // Track window and completion state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_open <= 1'b0;
            done     <= 1'b0;
        end else if (start_ev) begin
            win_open <= 1'b1;
            done     <= 1'b0;
        end else if (stop_ev && win_open) begin
            win_open <= 1'b0;
            done     <= 1'b1;
        end
    end

    assign clear = start_ev;
    assign step  = sclk_ev & win_open & ~stop_ev & ~start_ev;
endmodule

// File: rtl/sigan_lfsr.sv
// Serial-input signature register in internal-feedback form.
// Assumes TAP_MASK holds the polynomial terms below the top degree.
module sigan_lfsr #(
    parameter int unsigned        SIG_W    = 16,
    parameter logic [SIG_W-1:0]   TAP_MASK = 16'h1281
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             din,
    output logic [SIG_W-1:0] state
);
    logic             fb;
    logic [SIG_W-1:0] nxt;

    // Next value for one compaction step
    always_comb begin
        fb  = state[SIG_W-1] ^ din;
        nxt = {state[SIG_W-2:0], 1'b0} ^ (fb ? TAP_MASK : '0);
    end

    // Update the register on clear or step
    always_ff @(posedge clk) begin
        if (!rst_n)     state <= '0;
        else if (clear) state <= '0;
        else if (step)  state <= nxt;
    end
endmodule

// File: rtl/sigan_glyph.sv
// Converts the signature into one display character per nibble.
// Assumes SIG_W is a multiple of 4.
module sigan_glyph #(
    parameter int unsigned SIG_W = 16,
    localparam int unsigned DIGITS = SIG_W / 4
) (
    input  logic [SIG_W-1:0]    sig,
    output logic [8*DIGITS-1:0] chars
);
    import sigan_pkg::*;

    // One character per nibble, same order as the binary word
    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        assign chars[8*g +: 8] = nib_to_char(sig[4*g +: 4]);
    end
endmodule

// File: rtl/sigan_top.sv
// Windowed serial signature analyzer top.
// Assumes probe lines are asynchronous and slower than a few system cycles per level.
module sigan_top #(
    parameter int unsigned      SIG_W       = 16,
    parameter int unsigned      SYNC_STAGES = 2,
    parameter logic [SIG_W-1:0] TAP_MASK    = 16'h1281,
    localparam int unsigned     DIGITS      = SIG_W / 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic                sclk_i,
    input  logic                data_i,
    input  logic                start_fall_i,
    input  logic                stop_fall_i,
    input  logic                sclk_fall_i,
    input  logic [SIG_W-1:0]    expect_i,
    output logic                done_o,
    output logic [SIG_W-1:0]    sig_o,
    output logic [8*DIGITS-1:0] glyph_o,
    output logic                match_o
);
    import sigan_pkg::*;

    logic [EV_N:0]   raw_lines;
    logic [EV_N:0]   sync_lines;
    logic [EV_N-1:0] fall_sel;
    logic [EV_N-1:0] events;
    logic            start_ev, stop_ev, sclk_ev;
    logic            clear, step, win_open;

    // Bundle probe lines; data rides in the top bit so it keeps timing with the controls
    assign raw_lines[EV_START] = start_i;
    assign raw_lines[EV_STOP]  = stop_i;
    assign raw_lines[EV_SCLK]  = sclk_i;
    assign raw_lines[EV_N]     = data_i;

    assign fall_sel[EV_START] = start_fall_i;
    assign fall_sel[EV_STOP]  = stop_fall_i;
    assign fall_sel[EV_SCLK]  = sclk_fall_i;

    sigan_sync #(.WIDTH(EV_N + 1), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(sync_lines)
    );

    sigan_edge #(.WIDTH(EV_N)) i_edge (
        .clk(clk), .rst_n(rst_n), .lvl(sync_lines[EV_N-1:0]),
        .fall_sel(fall_sel), .ev(events)
    );

    assign start_ev = events[EV_START];
    assign stop_ev  = events[EV_STOP];
    assign sclk_ev  = events[EV_SCLK];

    sigan_window i_win (
        .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev),
        .sclk_ev(sclk_ev), .clear(clear), .step(step),
        .win_open(win_open), .done(done_o)
    );

    sigan_lfsr #(.SIG_W(SIG_W), .TAP_MASK(TAP_MASK)) i_lfsr (
        .clk(clk), .rst_n(rst_n), .clear(clear), .step(step),
        .din(sync_lines[EV_N]), .state(sig_o)
    );

    sigan_glyph #(.SIG_W(SIG_W)) i_glyph (
        .sig(sig_o), .chars(glyph_o)
    );

    // Compare is valid only once the window has closed
    assign match_o = done_o && (sig_o == expect_i);
endmodule

// File: rtl/sigan_chk.sv
// Property checker for sigan_top, attached by bind.
// Assumes it sees the internal event pulses and window state of the top.
module sigan_chk #(
    parameter int unsigned SIG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_ev,
    input logic             stop_ev,
    input logic             sclk_ev,
    input logic             win_open,
    input logic             done_o,
    input logic [SIG_W-1:0] sig_o,
    input logic             match_o
);
    // R3: a start event leaves a cleared signature and no done
    a_r3_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (sig_o == '0 && !done_o && win_open));

    // R6: a stop inside the window raises done
    a_r6_stop_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && stop_ev && !start_ev) |=> done_o);

    // R6: done is held until a start
    a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_ev) |=> done_o);

    // R6: window open and done never coexist
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_open && done_o));

    // R5: the signature is frozen while the window is shut
    a_r5_hold_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && !start_ev) |=> $stable(sig_o));

    // R4: without a sample-clock event the signature does not move
    a_r4_step_only_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_ev && !start_ev) |=> $stable(sig_o));

    // R8: stop takes priority over a coincident sample-clock event
    a_r8_stop_beats_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && stop_ev && sclk_ev && !start_ev) |=> $stable(sig_o));

    // R10: a match is only reported after the window closes
    a_r10_match_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> done_o);
endmodule

bind sigan_top sigan_chk #(.SIG_W(SIG_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev),
    .sclk_ev(sclk_ev), .win_open(win_open), .done_o(done_o),
    .sig_o(sig_o), .match_o(match_o)
);

// File: tb/test_sigan_top.sv
module test_sigan_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, stop_i = 1'b0, sclk_i = 1'b0, data_i = 1'b0;
    logic        start_fall_i = 1'b0, stop_fall_i = 1'b0, sclk_fall_i = 1'b0;
    logic [15:0] expect_i = '0;
    logic        done_o, match_o;
    logic [15:0] sig_o;
    logic [31:0] glyph_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk; // 250 MHz

    sigan_top i_sigan_top (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .sclk_i(sclk_i), .data_i(data_i), .start_fall_i(start_fall_i),
        .stop_fall_i(stop_fall_i), .sclk_fall_i(sclk_fall_i),
        .expect_i(expect_i), .done_o(done_o), .sig_o(sig_o),
        .glyph_o(glyph_o), .match_o(match_o)
    );

    // Vector layout: [23] start falling, [22] stop falling, [21] sclk falling,
    // [20:16] bit count, [15:0] data bits sent LSB first
    localparam int NVEC = 6;
    localparam logic [23:0] VEC [NVEC] = '{
        {3'b000, 5'd16, 16'hA5C3},
        {3'b001, 5'd8,  16'h00F1},
        {3'b110, 5'd12, 16'h0ABC},
        {3'b111, 5'd16, 16'hFFFF},
        {3'b010, 5'd1,  16'h0001},
        {3'b100, 5'd0,  16'h0000}
    };

    localparam logic [8*16-1:0] ALPHA = "0123456789ACFHPU";

    function automatic logic [15:0] model_step(input logic [15:0] s, input logic d);
        logic f;
        f = s[15] ^ d;
        s = {s[14:0], 1'b0};
        if (f) s = s ^ 16'h1281;
        return s;
    endfunction

    function automatic logic [15:0] model_run(input int n, input logic [15:0] pat);
        logic [15:0] s = '0;
        for (int i = 0; i < n; i++) s = model_step(s, pat[i]);
        return s;
    endfunction

    function automatic logic [31:0] model_glyph(input logic [15:0] s);
        logic [31:0] g;
        for (int k = 0; k < 4; k++) begin
            int v;
            v = int'(s[4*k +: 4]);
            g[8*k +: 8] = ALPHA[8*(15-v) +: 8];
        end
        return g;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pol(input logic [2:0] p);
        start_fall_i = p[2]; start_i = p[2];
        stop_fall_i  = p[1]; stop_i  = p[1];
        sclk_fall_i  = p[0]; sclk_i  = p[0];
        waitn(5);
    endtask

    task automatic pulse_start();
        start_i = ~start_fall_i; waitn(4); start_i = start_fall_i; waitn(4);
    endtask
    task automatic pulse_stop();
        stop_i = ~stop_fall_i; waitn(4); stop_i = stop_fall_i; waitn(4);
    endtask
    task automatic pulse_sclk();
        sclk_i = ~sclk_fall_i; waitn(4); sclk_i = sclk_fall_i; waitn(4);
    endtask

    task automatic send_bits(input int n, input logic [15:0] pat);
        for (int i = 0; i < n; i++) begin
            data_i = pat[i]; waitn(4);
            pulse_sclk();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %h expected %h", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] exp_s;
        logic [15:0] first_s;
        waitn(3);
        rst_n = 1'b1;
        waitn(4);
        // R1: reset state
        chk(sig_o == 16'h0, "R1 sig", 32'(sig_o), 0);
        chk(!done_o && !match_o, "R1 flags", {30'd0, done_o, match_o}, 0);
        chk(glyph_o == 32'h30303030, "R1 glyph", glyph_o, 32'h30303030);

        // R5: clock edges before any start are ignored
        data_i = 1'b1; waitn(4);
        pulse_sclk();
        chk(sig_o == 16'h0, "R5 before start", 32'(sig_o), 0);

        // R4 R7 R9 R10: table of windows with varied polarities
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0]  p;
            int          n;
            logic [15:0] pat;
            p = VEC[v][23:21]; n = int'(VEC[v][20:16]); pat = VEC[v][15:0];
            set_pol(p);
            exp_s = model_run(n, pat);
            expect_i = (v % 2 == 0) ? exp_s : (exp_s ^ 16'h0001);
            pulse_start();
            send_bits(n, pat);
            pulse_stop();
            chk(sig_o == exp_s, "R4/R7 signature", 32'(sig_o), 32'(exp_s));
            chk(done_o, "R6 done after stop", 32'(done_o), 1);
            chk(glyph_o == model_glyph(exp_s), "R9 glyph", glyph_o, model_glyph(exp_s));
            chk(match_o == (v % 2 == 0), "R10 match", 32'(match_o), 32'(v % 2 == 0));
        end

        // R5 R6: clock and stop after the window closes change nothing
        set_pol(3'b000);
        pulse_start();
        send_bits(5, 16'h0013);
        pulse_stop();
        first_s = model_run(5, 16'h0013);
        data_i = 1'b1; waitn(4);
        pulse_sclk();
        chk(sig_o == first_s, "R5 after stop", 32'(sig_o), 32'(first_s));
        pulse_stop();
        chk(done_o && sig_o == first_s, "R6 stop while closed", {15'd0, done_o, sig_o}, {15'd0, 1'b1, first_s});

        // R11: same stream again gives the same signature
        pulse_start();
        send_bits(5, 16'h0013);
        pulse_stop();
        chk(sig_o == first_s, "R11 repeat", 32'(sig_o), 32'(first_s));

        // R2: start takes effect on the third system edge
        start_i = 1'b1;
        waitn(2);
        chk(done_o == 1'b1, "R2 not before third edge", 32'(done_o), 1);
        waitn(1);
        chk(done_o == 1'b0 && sig_o == 16'h0, "R2 R3 after third edge", {15'd0, done_o, sig_o}, 0);
        start_i = 1'b0; waitn(4);

        // R10: no match while window open even if values agree
        expect_i = 16'h0000;
        chk(!match_o, "R10 open window", 32'(match_o), 0);

        // R8: stop and clock edges in the same cycle, stop wins
        send_bits(3, 16'h0005);
        exp_s = model_run(3, 16'h0005);
        data_i = 1'b1; waitn(4);
        sclk_i = 1'b1; stop_i = 1'b1; waitn(4);
        sclk_i = 1'b0; stop_i = 1'b0; waitn(4);
        chk(sig_o == exp_s && done_o, "R8 stop priority", {15'd0, done_o, sig_o}, {15'd0, 1'b1, exp_s});

        // R3: start after done clears everything
        pulse_start();
        chk(sig_o == 16'h0 && !done_o, "R3 restart", {15'd0, done_o, sig_o}, 0);

        // R7: inactive-direction edge on sample clock is ignored
        data_i = 1'b1; waitn(4);
        sclk_fall_i = 1'b1; sclk_i = 1'b1; waitn(4); // rise with falling selected
        chk(sig_o == 16'h0, "R7 wrong edge", 32'(sig_o), 0);
        sclk_i = 1'b0; waitn(4);                       // fall, now active
        chk(sig_o == 16'h1281, "R7 right edge", 32'(sig_o), 32'h1281);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule